// File: doc/BRIEF.md
# Multi-Read Field Store Synchroniser

This block sits between an input video field stream and an output timing generator that runs freely, with no lock to the input. Incoming samples are written through a single write port into one of three field slots. A downstream interpolator presents up to four line addresses at once and receives the four samples together, so it can pick the lines it needs straight from the store. No separate line-redistribution buffer is needed.

Because the two field rates drift against each other, the read side sometimes shows the same field twice and sometimes skips a field. Each output field pulse re-selects the slot to read. A one-cycle pulse reports every repeat and every drop. When the input and output field pulses lie close together, a programmable window of lines applies hysteresis. Once the block has chosen to wait for a field that is finishing near the output pulse, it keeps that choice until the phase leaves the window. This prevents a run of drops and repeats alternating from field to field.

The four read addresses share one memory read port. A free-running phase counter serves them in the fixed order 0, 1, 2, 3, so one output sample period is four clock cycles.

Top module: `fs_sync`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `drop_o`, `repeat_o` and `rd_valid_o` are 0. No drop or repeat pulse is issued until at least one input field has been completed.
- R2: The first `wr_field_i` pulse after reset opens slot 0 for writing. Each later pulse closes the slot being written, making it the newest complete field, and opens the one slot that is neither just closed nor being read. A write with `wr_en_i` high stores `wr_data_i` at (`wr_line_i`, `wr_pix_i`) in the open slot and never alters the slot being read.
- R3: The four read addresses in `rd_addr_i` are each `{line, pix}`, with port k at bits `[k*ADDR_W +: ADDR_W]`. They are fetched one per clock in the order 0, 1, 2, 3. `rd_valid_o` pulses high for one cycle in every four. In that cycle, lane k of `rd_data_o` (bits `[k*DATA_W +: DATA_W]`) holds the word that port k addresses in the read slot.
- R4: On an `rd_field_i` pulse, if a field has completed since the last slot change and no deferral applies, the read slot becomes the newest complete field.
- R5: One cycle after an `rd_field_i` pulse that leaves the read slot unchanged (once any field has completed), `repeat_o` is high for exactly one cycle.
- R6: If the field taken on an `rd_field_i` pulse is two or more completions newer than the previously taken one, `drop_o` is high for exactly one cycle, one cycle after the pulse.
- R7: The phase is the value of `wr_line_i` at the `rd_field_i` pulse. It is in the early zone if phase < `hyst_win_i`. It is in the late zone if phase >= 2^LINE_W − `hyst_win_i`, with `hyst_win_i` nonzero.
- R8: A pulse in the late zone sets a defer state. A pulse outside both zones clears it. A pulse in the early zone keeps it. While deferring, a pulse in the early zone does not take the newly completed field (a repeat results). Without deferral, an early-zone pulse takes it.
- R9: `drop_o` and `repeat_o` are never high together, and each is high only in the cycle after an `rd_field_i` pulse.
- R10: With `hyst_win_i` = 0 both zones are empty, so a pulse near the end of an input field causes no later deferral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, four cycles per output sample |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_field_i | input | 1 | Input field start pulse |
| wr_en_i | input | 1 | Write strobe |
| wr_line_i | input | LINE_W | Write line, also the phase reference |
| wr_pix_i | input | PIX_W | Write pixel |
| wr_data_i | input | DATA_W | Write sample |
| rd_field_i | input | 1 | Output field start pulse |
| hyst_win_i | input | LINE_W | Hysteresis window in lines |
| rd_addr_i | input | 4*(LINE_W+PIX_W) | Four read addresses `{line, pix}` |
| rd_data_o | output | 4*DATA_W | Four read samples |
| rd_valid_o | output | 1 | Read group complete |
| drop_o | output | 1 | Field skipped pulse |
| repeat_o | output | 1 | Field repeated pulse |

## Verification
The slot selection is driven with output pulses at a mid-field phase. These show a plain advance, a repeat when no new field has arrived, and a drop when two fields have completed. Pulses placed at the end of an input field and then just after its completion separate the deferred choice from the undeferred one. A pulse at a mid-field phase afterwards shows the deferral being released. Repeating the late-then-early pattern with a zero window shows that the window alone causes the deferral. Every read uses four distinct lines and pixels, so a wrong port order or a write into the slot being read shows up as a mismatched lane.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned NUM_SLOTS = 3;
  localparam int unsigned NUM_RD    = 4;

  typedef logic [1:0] slot_t;

  // the slot that is neither a nor b (a != b, both < 3)
  function automatic slot_t third_slot(slot_t a, slot_t b);
    return slot_t'(2'd3 - a - b);
  endfunction
endpackage

// File: rtl/fs_slot_ctrl.sv
module fs_slot_ctrl
  import fs_pkg::*;
#(
  parameter int unsigned LINE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_field_i,
  input  logic              rd_field_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [LINE_W-1:0] win_i,
  output slot_t             wr_slot_o,
  output slot_t             rd_slot_o,
  output logic              drop_o,
  output logic              repeat_o
);
  localparam logic [LINE_W:0] LINES = (LINE_W+1)'(1) << LINE_W;

  slot_t       wr_q, rd_q, done_q, wr_d, rd_d, done_d;
  logic [1:0]  pend_q, pend_d;
  logic        started_q, any_q, defer_q, defer_d;
  logic        drop_q, rep_q, take, closing, early, late;
  logic [LINE_W:0] line_ext, win_ext;

  assign line_ext = {1'b0, wr_line_i};
  assign win_ext  = {1'b0, win_i};
  assign early    = line_ext < win_ext;
  assign late     = (win_i != '0) && (line_ext >= (LINES - win_ext));
  assign closing  = wr_field_i && started_q;

  always_comb begin
    defer_d = defer_q;
    take    = 1'b0;
    rd_d    = rd_q;
    if (rd_field_i) begin
      if (late)        defer_d = 1'b1;
      else if (!early) defer_d = 1'b0;
      take = (pend_q != 2'd0) && !(early && defer_d);
      if (take) rd_d = done_q;
    end
    pend_d = take ? 2'd0 : pend_q;
    if (closing && pend_d != 2'd2) pend_d = pend_d + 2'd1;
    wr_d   = closing ? third_slot(wr_q, rd_d) : wr_q;
    done_d = closing ? wr_q : done_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 2'd0;
      rd_q      <= 2'd1;
      done_q    <= 2'd1;
      pend_q    <= 2'd0;
      started_q <= 1'b0;
      any_q     <= 1'b0;
      defer_q   <= 1'b0;
      drop_q    <= 1'b0;
      rep_q     <= 1'b0;
    end else begin
      wr_q      <= wr_d;
      rd_q      <= rd_d;
      done_q    <= done_d;
      pend_q    <= pend_d;
      started_q <= started_q | wr_field_i;
      any_q     <= any_q | closing;
      defer_q   <= defer_d;
      drop_q    <= take && (pend_q == 2'd2);
      rep_q     <= rd_field_i && any_q && !take;
    end
  end

  assign wr_slot_o = wr_q;
  assign rd_slot_o = rd_q;
  assign drop_o    = drop_q;
  assign repeat_o  = rep_q;
endmodule

// File: rtl/fs_store.sv
module fs_store
  import fs_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  slot_t             wslot_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  slot_t             rslot_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [NUM_SLOTS][DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && wslot_i < 2'(NUM_SLOTS)) mem_q[wslot_i][waddr_i] <= wdata_i;
    if (rslot_i < 2'(NUM_SLOTS)) rdata_o <= mem_q[rslot_i][raddr_i];
    else                         rdata_o <= '0;
  end
endmodule

// File: rtl/fs_read_mux.sv
module fs_read_mux #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_RD   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_RD*ADDR_W-1:0]   rd_addr_i,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic [ADDR_W-1:0]        mem_raddr_o,
  output logic [N_RD*DATA_W-1:0]   rd_data_o,
  output logic                     rd_valid_o
);
  localparam int unsigned PH_W = (N_RD > 1) ? $clog2(N_RD) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(N_RD - 1);

  logic [PH_W-1:0]   ph_q, ph_d1_q;
  logic              vld_d1_q, valid_q;
  logic [DATA_W-1:0] lane_q [N_RD];

  assign mem_raddr_o = rd_addr_i[ph_q*ADDR_W +: ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= '0;
      ph_d1_q  <= LAST;
      vld_d1_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      ph_q     <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
      ph_d1_q  <= ph_q;
      vld_d1_q <= 1'b1;
      valid_q  <= vld_d1_q && (ph_d1_q == LAST);
    end
  end

  for (genvar k = 0; k < N_RD; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   lane_q[k] <= '0;
      else if (vld_d1_q && ph_d1_q == PH_W'(k))      lane_q[k] <= mem_rdata_i;
    end
    assign rd_data_o[k*DATA_W +: DATA_W] = lane_q[k];
  end

  assign rd_valid_o = valid_q;
endmodule

// File: rtl/fs_sync.sv
module fs_sync
  import fs_pkg::*;
#(
  parameter int unsigned LINE_W = 3,
  parameter int unsigned PIX_W  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = LINE_W + PIX_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_field_i,
  input  logic                       wr_en_i,
  input  logic [LINE_W-1:0]          wr_line_i,
  input  logic [PIX_W-1:0]           wr_pix_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       rd_field_i,
  input  logic [LINE_W-1:0]          hyst_win_i,
  input  logic [NUM_RD*ADDR_W-1:0]   rd_addr_i,
  output logic [NUM_RD*DATA_W-1:0]   rd_data_o,
  output logic                       rd_valid_o,
  output logic                       drop_o,
  output logic                       repeat_o
);
  slot_t             wr_slot, rd_slot;
  logic [ADDR_W-1:0] mem_raddr;
  logic [DATA_W-1:0] mem_rdata;

  fs_slot_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_field_i, .rd_field_i, .wr_line_i,
    .win_i    (hyst_win_i),
    .wr_slot_o(wr_slot),
    .rd_slot_o(rd_slot),
    .drop_o,
    .repeat_o
  );

  fs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i,
    .we_i   (wr_en_i),
    .wslot_i(wr_slot),
    .waddr_i({wr_line_i, wr_pix_i}),
    .wdata_i(wr_data_i),
    .rslot_i(rd_slot),
    .raddr_i(mem_raddr),
    .rdata_o(mem_rdata)
  );

  fs_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_RD(NUM_RD)) u_rmux (
    .clk_i, .rst_ni, .rd_addr_i,
    .mem_rdata_i(mem_rdata),
    .mem_raddr_o(mem_raddr),
    .rd_data_o,
    .rd_valid_o
  );
endmodule

// File: rtl/fs_sync_chk.sv
module fs_sync_chk
  import fs_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  wr_field_i,
  input logic  rd_field_i,
  input slot_t wr_slot_i,
  input slot_t rd_slot_i,
  input logic  drop_i,
  input logic  repeat_i,
  input logic  rd_valid_i
);
  assert_slot_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_slot_i < 2'(NUM_SLOTS) && rd_slot_i < 2'(NUM_SLOTS));

  assert_wr_avoids_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_slot_i != rd_slot_i);

  assert_wr_slot_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_field_i |=> $stable(wr_slot_i));

  assert_rd_slot_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_field_i |=> $stable(rd_slot_i));

  assert_valid_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> !rd_valid_i ##1 !rd_valid_i ##1 !rd_valid_i ##1 rd_valid_i);

  assert_pulse_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drop_i && repeat_i));

  assert_drop_after_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drop_i) |-> $past(rd_field_i));

  assert_repeat_after_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(repeat_i) |-> $past(rd_field_i));

  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_i || repeat_i) |=> !(drop_i || repeat_i) || $past(rd_field_i));
endmodule

bind fs_sync fs_sync_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_field_i(wr_field_i),
  .rd_field_i(rd_field_i),
  .wr_slot_i (wr_slot),
  .rd_slot_i (rd_slot),
  .drop_i    (drop_o),
  .repeat_i  (repeat_o),
  .rd_valid_i(rd_valid_o)
);

// File: tb/test_fs_sync.sv
module test_fs_sync;
  localparam int LINE_W = 3, PIX_W = 4, DATA_W = 8, ADDR_W = LINE_W + PIX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_field = 0, wr_en = 0, rd_field = 0;
  logic [LINE_W-1:0] wr_line = '0, win = 3'd2;
  logic [PIX_W-1:0]  wr_pix = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [4*ADDR_W-1:0] rd_addr = '0;
  logic [4*DATA_W-1:0] rd_data;
  logic rd_valid, drop, rep;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  fs_sync #(.LINE_W(LINE_W), .PIX_W(PIX_W), .DATA_W(DATA_W)) i_fs_sync (
    .clk_i(clk), .rst_ni(rst_n), .wr_field_i(wr_field), .wr_en_i(wr_en),
    .wr_line_i(wr_line), .wr_pix_i(wr_pix), .wr_data_i(wr_data),
    .rd_field_i(rd_field), .hyst_win_i(win), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .drop_o(drop), .repeat_o(rep));

  function automatic logic [7:0] pat(int id, int l, int p);
    return 8'((id * 53 + l * 16 + p) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_pulse();
    @(posedge clk) #1 wr_field = 1;
    @(posedge clk) #1 wr_field = 0;
  endtask

  task automatic fill(int id);
    for (int l = 0; l < 8; l++)
      for (int p = 0; p < 16; p++) begin
        @(posedge clk) #1;
        wr_en = 1; wr_line = 3'(l); wr_pix = 4'(p); wr_data = pat(id, l, p);
      end
    @(posedge clk) #1 wr_en = 0;
  endtask

  // output field pulse at phase pos; check drop/repeat the cycle after
  task automatic rd_pulse(int pos, int exp_drop, int exp_rep, string req);
    @(posedge clk) #1; wr_line = 3'(pos); rd_field = 1;
    @(posedge clk) #1 rd_field = 0;
    @(negedge clk);
    check({req, " drop"}, int'(drop), exp_drop);
    check({req, " repeat"}, int'(rep), exp_rep);
    @(negedge clk);
    check({req, " pulse width"}, int'(drop | rep), 0);
  endtask

  // four ports on distinct lines/pixels; checks each lane holds field id
  task automatic check_field(int id, string req);
    for (int k = 0; k < 4; k++)
      rd_addr[k*ADDR_W +: ADDR_W] = {3'(2*k + 1), 4'(k + 5)};
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      while (!rd_valid) @(negedge clk);
    end
    for (int k = 0; k < 4; k++)
      check($sformatf("%s lane%0d", req, k), int'(rd_data[k*DATA_W +: DATA_W]),
            int'(pat(id, 2*k + 1, k + 5)));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset drop", int'(drop), 0);
    check("R1 reset repeat", int'(rep), 0);
    check("R1 reset valid", int'(rd_valid), 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R1 after reset valid", int'(rd_valid), 0);
    rd_pulse(3, 0, 0, "R1 no field yet");
  endtask

  task automatic t_period();
    int gap = 0;
    @(negedge clk); while (!rd_valid) @(negedge clk);
    @(negedge clk); gap = 1;
    while (!rd_valid) begin @(negedge clk); gap++; end
    check("R3 valid period", gap, 4);
  endtask

  task automatic t_advance();
    wr_pulse(); fill(1); wr_pulse();
    rd_pulse(4, 0, 0, "R4 advance");
    check_field(1, "R4 R2 R3 field1");
    rd_pulse(4, 0, 1, "R5 repeat");
    check_field(1, "R5 field1 kept");
  endtask

  task automatic t_drop();
    fill(2); wr_pulse(); fill(3); wr_pulse();
    rd_pulse(4, 1, 0, "R6 drop");
    check_field(3, "R6 field3");
  endtask

  task automatic t_hyst();
    fill(4);
    rd_pulse(7, 0, 1, "R7 late zone");
    check_field(3, "R2 write avoids read slot");
    wr_pulse();
    rd_pulse(1, 0, 1, "R8 deferred early");
    check_field(3, "R8 field3 held");
    fill(5); wr_pulse();
    rd_pulse(4, 1, 0, "R8 release");
    check_field(5, "R8 field5");
    fill(6); wr_pulse();
    rd_pulse(1, 0, 0, "R8 undeferred early");
    check_field(6, "R8 field6");
  endtask

  task automatic t_zero_win();
    win = '0;
    fill(7);
    rd_pulse(7, 0, 1, "R10 no late zone");
    wr_pulse();
    rd_pulse(0, 0, 0, "R10 no defer");
    check_field(7, "R10 field7");
  endtask

  initial begin
    fork
      begin
        t_reset(); t_period(); t_advance(); t_drop(); t_hyst(); t_zero_win();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule